// File: doc/BRIEF.md
# Write Buffer With Read-Miss Bypass

This block is a small queue of pending stores that sits between a cache and the next level of memory. The cache hands it write requests and carries on without stalling as long as a slot is free. The queued writes leave for memory one at a time, in arrival order, through a request/acknowledge port.

A read miss from the cache is accepted one at a time. Its address is compared with every queued write address. When one or more queued writes match, the data of the youngest match is handed back on the next cycle and no memory read is made. When nothing matches, the read goes to memory ahead of the queued writes. A build-time option, `WAIT_EMPTY`, swaps this for a plain scheme. In that scheme the read is held back until every queued write has drained, and no forwarding takes place.

The memory port carries both kinds of traffic. `mem_req_write` = 1 marks a write, with `mem_req_data` as its payload. `mem_req_write` = 0 marks a read. A request is taken in any cycle where `mem_req_valid` and `mem_req_ready` are both high. Read data comes back later as a one-cycle `mem_rd_valid` pulse.

Top module: `wbuf_bypass`

## Requirements
- R1: `wr_ready` is high whenever fewer than `DEPTH` (default 4) writes are queued and no plain-mode read is pending. It is low while all `DEPTH` slots are full. A write can enter in the same cycle as another one leaves.
- R2: Queued writes are offered to memory with `mem_req_write` = 1. They leave in the order they were accepted, with the address and data that were accepted, one for each acknowledged request.
- R3: In bypass mode, a read miss whose address equals one or more queued write addresses gets `rd_resp_valid` in the cycle after it is accepted. The data is that of the most recently accepted matching write. No memory read (`mem_req_write` = 0) is accepted for it.
- R4: In bypass mode, a read miss with no matching queued address is offered to memory in the cycle after it is accepted, with `mem_req_write` = 0 and its own address. This happens even while older writes are still queued, because it takes priority over them.
- R5: Data returned on `mem_rd_data` with `mem_rd_valid` appears on `rd_resp_data` with `rd_resp_valid` one cycle later.
- R6: Only one read miss is in flight. `rd_ready` is low from the cycle after acceptance through the cycle of the response. `rd_resp_valid` is a single-cycle pulse.
- R7: With `WAIT_EMPTY` = 1, a read miss is not offered to memory until every write queued before it has been acknowledged. Writes are refused (`wr_ready` low) from the cycle after the read is accepted until its response.
- R8: After reset, `wr_ready` and `rd_ready` are high, and `mem_req_valid` and `rd_resp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Cache offers a write |
| wr_ready | output | 1 | Buffer can take a write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data (one block) |
| rd_valid | input | 1 | Cache offers a read miss |
| rd_ready | output | 1 | Read miss can be accepted |
| rd_addr | input | ADDR_W | Read miss address |
| rd_resp_valid | output | 1 | Read data valid (one cycle) |
| rd_resp_data | output | DATA_W | Read data |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory acknowledges the request |
| mem_req_write | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_data | output | DATA_W | Write payload |
| mem_rd_valid | input | 1 | Memory read data valid |
| mem_rd_data | input | DATA_W | Memory read data |

## Verification
The bench aims at the cases where forwarding and reordering can go wrong.

Two writes to the same address sit in the queue when that address is read. A design that picked the oldest match would return stale data.

A read is issued while memory is stalled and the queue is full. A design without read priority would offer a write first and break R4. A design that forgot to compare addresses would make an extra memory read on a hit.

In the wait-for-empty build, the bench counts how many writes leave before the read does. It also watches `wr_ready`. A design that let the read jump ahead, or kept taking writes, would starve or reorder the read.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_ISSUE = 2'd1,
    RD_WAIT  = 2'd2,
    RD_RESP  = 2'd3
  } rd_state_e;

  // slot reached by stepping 'step' places past 'base' in a ring of 'depth'
  function automatic int unsigned ring_slot(input int unsigned base,
                                            input int unsigned step,
                                            input int unsigned depth);
    return (base + step) % depth;
  endfunction

endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push,
  input  logic [ADDR_W-1:0]             push_addr,
  input  logic [DATA_W-1:0]             push_data,
  input  logic                          pop,
  output logic [ADDR_W-1:0]             head_addr,
  output logic [DATA_W-1:0]             head_data,
  output logic [PTR_W-1:0]              head_ptr,
  output logic [CNT_W-1:0]              count,
  output logic                          full,
  output logic                          empty,
  output logic [DEPTH-1:0]              ent_vld,
  output logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr,
  output logic [DEPTH-1:0][DATA_W-1:0]  ent_data
);

  logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
  logic [DEPTH-1:0][DATA_W-1:0] data_q;
  logic [DEPTH-1:0]             vld_q;
  logic [PTR_W-1:0]             head_q, tail_q;
  logic [CNT_W-1:0]             cnt_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail_q] <= push_addr;
      data_q[tail_q] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop) begin
        vld_q[head_q] <= 1'b0;
        head_q        <= bump(head_q);
      end
      if (push) begin
        vld_q[tail_q] <= 1'b1;
        tail_q        <= bump(tail_q);
      end
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head_addr = addr_q[head_q];
  assign head_data = data_q[head_q];
  assign head_ptr  = head_q;
  assign count     = cnt_q;
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign ent_vld   = vld_q;
  assign ent_addr  = addr_q;
  assign ent_data  = data_q;

endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]             ent_vld,
  input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
  input  logic [DEPTH-1:0][DATA_W-1:0] ent_data,
  input  logic [PTR_W-1:0]             head_ptr,
  input  logic [ADDR_W-1:0]            q_addr,
  output logic                         hit,
  output logic [DATA_W-1:0]            hit_data
);

  // walk from oldest to youngest; a later match overrides an earlier one
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      int unsigned s;
      s = wbuf_pkg::ring_slot(int'(head_ptr), k, DEPTH);
      if (ent_vld[s] && (ent_addr[s] == q_addr)) begin
        hit      = 1'b1;
        hit_data = ent_data[s];
      end
    end
  end

endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass #(
  parameter int DEPTH      = 4,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 128,
  parameter int WAIT_EMPTY = 0,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_resp_valid,
  output logic [DATA_W-1:0] rd_resp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_data,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data
);
  import wbuf_pkg::*;

  localparam bit PLAIN = (WAIT_EMPTY != 0);

  rd_state_e         rd_st_q;
  logic [ADDR_W-1:0] miss_addr_q;
  logic [DATA_W-1:0] resp_data_q;

  // named internal events
  logic                         wr_push, wr_pop;
  logic                         rd_accept, fwd_hit, rd_issue_ok, rd_waiting;
  logic [DATA_W-1:0]            fwd_data;
  logic [ADDR_W-1:0]            head_addr;
  logic [DATA_W-1:0]            head_data;
  logic [PTR_W-1:0]             head_ptr;
  logic [CNT_W-1:0]             buf_count;
  logic                         buf_full, buf_empty;
  logic [DEPTH-1:0]             ent_vld;
  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
  logic [DEPTH-1:0][DATA_W-1:0] ent_data;

  wbuf_fifo #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(wr_push), .push_addr(wr_addr), .push_data(wr_data),
    .pop(wr_pop),
    .head_addr(head_addr), .head_data(head_data), .head_ptr(head_ptr),
    .count(buf_count), .full(buf_full), .empty(buf_empty),
    .ent_vld(ent_vld), .ent_addr(ent_addr), .ent_data(ent_data)
  );

  generate
    if (!PLAIN) begin : g_fwd
      wbuf_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
        .ent_vld(ent_vld), .ent_addr(ent_addr), .ent_data(ent_data),
        .head_ptr(head_ptr), .q_addr(rd_addr),
        .hit(fwd_hit), .hit_data(fwd_data)
      );
    end else begin : g_plain
      assign fwd_hit  = 1'b0;
      assign fwd_data = '0;
    end
  endgenerate

  assign rd_ready    = (rd_st_q == RD_IDLE);
  assign rd_accept   = rd_valid && rd_ready;
  assign rd_waiting  = (rd_st_q == RD_WAIT);
  assign rd_issue_ok = (rd_st_q == RD_ISSUE) && (!PLAIN || buf_empty);

  assign wr_ready = !buf_full && !(PLAIN && (rd_st_q != RD_IDLE));
  assign wr_push  = wr_valid && wr_ready;

  // read miss owns the port when it may go; otherwise the oldest write
  assign mem_req_valid = rd_issue_ok || !buf_empty;
  assign mem_req_write = !rd_issue_ok;
  assign mem_req_addr  = rd_issue_ok ? miss_addr_q : head_addr;
  assign mem_req_data  = head_data;
  assign wr_pop        = mem_req_valid && mem_req_ready && !rd_issue_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_st_q     <= RD_IDLE;
      miss_addr_q <= '0;
      resp_data_q <= '0;
    end else begin
      unique case (rd_st_q)
        RD_IDLE: if (rd_accept) begin
          if (fwd_hit) begin
            resp_data_q <= fwd_data;
            rd_st_q     <= RD_RESP;
          end else begin
            miss_addr_q <= rd_addr;
            rd_st_q     <= RD_ISSUE;
          end
        end
        RD_ISSUE: if (rd_issue_ok && mem_req_ready) rd_st_q <= RD_WAIT;
        RD_WAIT: if (mem_rd_valid) begin
          resp_data_q <= mem_rd_data;
          rd_st_q     <= RD_RESP;
        end
        RD_RESP: rd_st_q <= RD_IDLE;
        default: rd_st_q <= RD_IDLE;
      endcase
    end
  end

  assign rd_resp_valid = (rd_st_q == RD_RESP);
  assign rd_resp_data  = resp_data_q;

endmodule

// File: rtl/wbuf_bypass_chk.sv
module wbuf_bypass_chk #(
  parameter int DEPTH      = 4,
  parameter int DATA_W     = 128,
  parameter int WAIT_EMPTY = 0,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_ready,
  input logic              rd_ready,
  input logic              rd_accept,
  input logic              fwd_hit,
  input logic              rd_waiting,
  input logic              rd_resp_valid,
  input logic [DATA_W-1:0] rd_resp_data,
  input logic              mem_req_valid,
  input logic              mem_req_write,
  input logic              mem_rd_valid,
  input logic [DATA_W-1:0] mem_rd_data,
  input logic [CNT_W-1:0]  buf_count
);

  // R1
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_count == CNT_W'(DEPTH)) |-> !wr_ready);

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_count <= CNT_W'(DEPTH));

  // R3
  fwd_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_accept && fwd_hit) |=> (rd_resp_valid && !(mem_req_valid && !mem_req_write)));

  // R5
  mem_data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_waiting && mem_rd_valid) |=> (rd_resp_valid && rd_resp_data == $past(mem_rd_data)));

  // R6
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_resp_valid |=> !rd_resp_valid);

  // R6
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_resp_valid |-> !rd_ready);

  // R7
  plain_read_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_write) |-> (WAIT_EMPTY == 0 || buf_count == '0));

endmodule

bind wbuf_bypass wbuf_bypass_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .WAIT_EMPTY(WAIT_EMPTY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .rd_ready(rd_ready),
  .rd_accept(rd_accept), .fwd_hit(fwd_hit), .rd_waiting(rd_waiting),
  .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
  .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
  .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
  .buf_count(buf_count)
);

// File: tb/wbuf_bypass_test.sv
`timescale 1ns/1ps
module wbuf_bypass_test;

  localparam int AW = 32;
  localparam int DW = 128;
  localparam time T = 20ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(T/2) clk = ~clk;

  // bypass-mode instance
  logic          wr_valid = 0, rd_valid = 0, mem_rd_valid = 0, mem_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, mem_rd_data = '0;
  logic          wr_ready, rd_ready, rd_resp_valid, mem_req_valid, mem_req_write;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] rd_resp_data, mem_req_data;

  wbuf_bypass uut (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_en),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  // wait-for-empty instance
  logic          w_wr_valid = 0, w_rd_valid = 0, w_mem_rd_valid = 0, w_mem_en = 0;
  logic [AW-1:0] w_wr_addr = '0, w_rd_addr = '0;
  logic [DW-1:0] w_wr_data = '0, w_mem_rd_data = '0;
  logic          w_wr_ready, w_rd_ready, w_rd_resp_valid, w_mem_req_valid, w_mem_req_write;
  logic [AW-1:0] w_mem_req_addr;
  logic [DW-1:0] w_rd_resp_data, w_mem_req_data;

  wbuf_bypass #(.WAIT_EMPTY(1)) uut_w (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(w_wr_valid), .wr_ready(w_wr_ready), .wr_addr(w_wr_addr), .wr_data(w_wr_data),
    .rd_valid(w_rd_valid), .rd_ready(w_rd_ready), .rd_addr(w_rd_addr),
    .rd_resp_valid(w_rd_resp_valid), .rd_resp_data(w_rd_resp_data),
    .mem_req_valid(w_mem_req_valid), .mem_req_ready(w_mem_en),
    .mem_req_write(w_mem_req_write), .mem_req_addr(w_mem_req_addr), .mem_req_data(w_mem_req_data),
    .mem_rd_valid(w_mem_rd_valid), .mem_rd_data(w_mem_rd_data)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mem_init(input logic [AW-1:0] a);
    return {4{a ^ 32'h5A5A_0000}};
  endfunction

  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } wr_t;
  typedef struct { logic [DW-1:0] d; bit hit; int cyc; int nrd; } exp_t;

  wr_t           shadow[$];
  exp_t          exp_q[$];
  logic [DW-1:0] mem_q [logic [AW-1:0]];
  int            cyc = 0;
  int            n_mem_rd = 0;
  int            rd_lat = -1;
  logic [DW-1:0] rd_val = '0;

  function automatic logic [DW-1:0] mem_get(input logic [AW-1:0] a);
    return mem_q.exists(a) ? mem_q[a] : mem_init(a);
  endfunction

  // memory model + scoreboard monitor (samples 5 ns after the falling edge)
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      mem_rd_valid = 1'b0;
      if (rd_lat > 0) rd_lat--;
      if (rd_lat == 0) begin
        mem_rd_valid = 1'b1;
        mem_rd_data  = rd_val;
        rd_lat       = -1;
      end
      #5;
      if (rst_n) begin
        if (rd_resp_valid) begin
          if (exp_q.size() == 0) check(1'b0, "R6 unexpected response", rd_resp_data, '0);
          else begin
            exp_t e;
            e = exp_q.pop_front();
            check(rd_resp_data == e.d, e.hit ? "R3 forwarded data" : "R5 memory data",
                  rd_resp_data, e.d);
            if (e.hit) begin
              check(cyc == e.cyc + 1, "R3 forward latency", DW'(cyc), DW'(e.cyc + 1));
              check(n_mem_rd == e.nrd, "R3 no memory read on hit", DW'(n_mem_rd), DW'(e.nrd));
            end
          end
        end
        if (mem_req_valid && mem_en && mem_req_write) begin
          if (shadow.size() == 0) check(1'b0, "R2 write with empty model", DW'(mem_req_addr), '0);
          else begin
            wr_t w;
            w = shadow.pop_front();
            check(mem_req_addr == w.a && mem_req_data == w.d, "R2 drain order",
                  mem_req_data, w.d);
            mem_q[w.a] = w.d;
          end
        end
        if (mem_req_valid && mem_en && !mem_req_write) begin
          n_mem_rd++;
          rd_val = mem_get(mem_req_addr);
          rd_lat = 2;
        end
        if (rd_valid && rd_ready) begin
          exp_t e;
          e.hit = 1'b0;
          e.d   = mem_get(rd_addr);
          for (int i = 0; i < shadow.size(); i++)
            if (shadow[i].a == rd_addr) begin e.hit = 1'b1; e.d = shadow[i].d; end
          e.cyc = cyc;
          e.nrd = n_mem_rd;
          exp_q.push_back(e);
        end
        if (wr_valid && wr_ready) begin
          wr_t w;
          w.a = wr_addr; w.d = wr_data;
          shadow.push_back(w);
        end
      end
    end
  end

  task automatic push_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    #5;
    while (!wr_ready) begin @(negedge clk); #5; end
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic issue_rd(input logic [AW-1:0] a);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    #5;
    while (!rd_ready) begin @(negedge clk); #5; end
    @(posedge clk); #1;
    rd_valid = 1'b0;
    @(negedge clk); #5;
    // R6: no second read accepted while one is in flight
    check(rd_ready == 1'b0, "R6 rd_ready low after accept", DW'(rd_ready), '0);
  endtask

  task automatic settle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (shadow.size() == 0 && exp_q.size() == 0 && rd_lat < 0) break;
    end
    #6;
  endtask

  initial begin
    #(T * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    // R8 reset state
    check(wr_ready == 1'b1, "R8 wr_ready", DW'(wr_ready), 1);
    check(rd_ready == 1'b1, "R8 rd_ready", DW'(rd_ready), 1);
    check(mem_req_valid == 1'b0, "R8 mem_req_valid", DW'(mem_req_valid), 0);
    check(rd_resp_valid == 1'b0, "R8 rd_resp_valid", DW'(rd_resp_valid), 0);

    // R2: plain drain with memory ready
    mem_en = 1'b1;
    push_wr(32'h10, {4{32'h1111_0001}});
    push_wr(32'h14, {4{32'h1111_0002}});
    push_wr(32'h18, {4{32'h1111_0003}});
    settle();

    // R1 / R3: fill with memory stalled, two writes to the same address
    mem_en = 1'b0;
    push_wr(32'hA0, {4{32'hD1D1_0001}});
    push_wr(32'hB0, {4{32'hE0E0_0002}});
    push_wr(32'hA0, {4{32'hD2D2_0003}});
    push_wr(32'hC0, {4{32'hF0F0_0004}});
    @(negedge clk); #5;
    check(wr_ready == 1'b0, "R1 full deasserts wr_ready", DW'(wr_ready), 0);
    issue_rd(32'hA0);   // expect youngest match, next cycle
    @(negedge clk);

    // R4: non-matching miss goes ahead of four queued writes
    issue_rd(32'hD0);
    check(mem_req_valid && !mem_req_write && mem_req_addr == 32'hD0,
          "R4 read offered before writes", DW'(mem_req_addr), DW'(32'hD0));
    @(negedge clk);
    mem_en = 1'b1;
    settle();

    // R1: back-to-back writes while draining (enqueue and dequeue together)
    for (int i = 0; i < 6; i++) push_wr(32'h200 + 4 * i, {4{32'h3000_0000 + i}});
    settle();

    // R5: read of a drained address comes from memory with the drained value
    issue_rd(32'h208);
    settle();
    issue_rd(32'h14);
    settle();

    // R7: wait-for-empty build
    w_mem_en = 1'b0;
    @(negedge clk); w_wr_valid = 1'b1; w_wr_addr = 32'h100; w_wr_data = {4{32'hAAAA_0001}};
    @(negedge clk); w_wr_addr = 32'h104; w_wr_data = {4{32'hAAAA_0002}};
    @(negedge clk); w_wr_valid = 1'b0; w_rd_valid = 1'b1; w_rd_addr = 32'h200;
    @(negedge clk); w_rd_valid = 1'b0;
    #5;
    check(w_mem_req_valid && w_mem_req_write, "R7 write offered while queue busy",
          DW'(w_mem_req_write), 1);
    check(w_wr_ready == 1'b0, "R7 writes refused while read pending", DW'(w_wr_ready), 0);
    begin
      int nw = 0;
      bit seen = 0;
      w_mem_en = 1'b1;
      for (int i = 0; i < 20 && !seen; i++) begin
        if (i > 0) begin @(negedge clk); #5; end
        if (w_mem_req_valid && w_mem_req_write) nw++;
        else if (w_mem_req_valid) begin
          seen = 1;
          check(nw == 2, "R7 both writes drained before read", DW'(nw), 2);
          check(w_mem_req_addr == 32'h200, "R7 read address", DW'(w_mem_req_addr), DW'(32'h200));
        end
      end
      check(seen, "R7 read eventually offered", DW'(seen), 1);
    end
    @(negedge clk);
    w_mem_rd_valid = 1'b1; w_mem_rd_data = {4{32'hCAFE_0200}};
    @(negedge clk);
    w_mem_rd_valid = 1'b0;
    #5;
    check(w_rd_resp_valid && w_rd_resp_data == {4{32'hCAFE_0200}}, "R5 plain-mode response",
          w_rd_resp_data, {4{32'hCAFE_0200}});

    check(exp_q.size() == 0 && shadow.size() == 0, "R2 scoreboard drained",
          DW'(exp_q.size() + shadow.size()), 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule